// File: doc/BRIEF.md
# Bus Target Data-Phase Controller

This block is the target side of a multiplexed address/data bus with active-low handshakes. On the clock where the bus frame signal is first seen asserted, it captures the address and command from the shared lines. If the command is a memory read or a memory write and the address falls inside its window of `WORDS` 32-bit registers, it claims the cycle with its device-select output. It then paces each data phase with its ready output against the internal register array.

A word moves only on a clock edge where the initiator-ready and target-ready inputs are both low. Writes store only the byte lanes whose enables are low. Reads keep the data lines driven through wait states. A linear burst steps one word per completed phase. A burst that reaches the last word of the window is stopped there with a disconnect that carries data. When the transaction ends, the shared control lines are driven high for one clock and then released.

Top module: `bus_target_ctrl`

## Requirements
- R1: On the rising edge where `frame_ni` is first seen low, the block captures `ad_i` and `cbe_ni`. It claims the transaction only when all of the following hold: the command is 4'b0110 (memory read) or 4'b0111 (memory write); `ad_i[1:0]` is 2'b00; and the address lies in [BASE_ADDR, BASE_ADDR + 4*WORDS). On a claim, `devsel_no` is low from the next clock on. Any other command or address leaves every output inactive.
- R2: `trdy_no` and `stop_no` are never low unless `devsel_no` is low.
- R3: With INIT_WAIT = 1, the first write phase has `trdy_no` low in the second clock after the address edge. On a read, `ad_oe_o` stays low in the first clock after the address edge for turnaround, and `trdy_no` goes low in the third clock.
- R4: A word moves only on an edge where both `irdy_ni` and `trdy_no` are low. Once `trdy_no` is low, it stays low until such an edge, so an initiator stall neither skips nor repeats a word.
- R5: During a read wait state, `ad_oe_o` stays high while `trdy_no` is high.
- R6: On a write phase, byte lane k (`ad_i[8k+7:8k]`) is stored only when `cbe_ni[k]` is low. Lanes whose enable is high keep their old value. Byte enables have no effect on reads.
- R7: When a phase completes with `frame_ni` high, `devsel_no` and `trdy_no` are high in the next clock.
- R8: After a transaction, `devsel_no`, `trdy_no` and `stop_no` are driven high with `ctl_oe_o` high for exactly one clock. In the clock after that, `ctl_oe_o` is low.
- R9: Each completed phase of a burst moves to the next word, which is the address plus 4.
- R10: In the phase for word WORDS-1, `stop_no` is low together with `trdy_no`, and that word is the last one transferred. If `frame_ni` is still low after that phase, `stop_no` stays low with `trdy_no` high until `frame_ni` goes high.
- R11: After reset, all handshake outputs are high, both enables are low, and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Transaction frame from the initiator, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| ad_i | input | 32 | Address/data lines as seen at the pins |
| cbe_ni | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| ad_o | output | 32 | Read data toward the pins |
| ad_oe_o | output | 1 | Drive enable for `ad_o` |
| devsel_no | output | 1 | Device select, active low |
| trdy_no | output | 1 | Target ready, active low |
| stop_no | output | 1 | Stop request, active low |
| ctl_oe_o | output | 1 | Drive enable for the three target handshake lines |

## Verification
The address edge is clock 0. Device select is due at clock 1. With one initial wait state, target ready is due at clock 2 for a write and at clock 3 for a read. Release of the handshake lines is due one clock after the final phase, and the enable drops one clock later. The bench drives each phase on the falling edge, then samples one nanosecond later. At that point the outputs reflect the previous rising edge, and the inputs for the coming edge are already stable. The bench therefore knows whether the coming edge moves a word and counts each transfer in its own model. The counts of words moved, the iteration of the first transfer, the presence of the stop request, and the read data are all compared with values derived from the start word, the burst length and the byte enables.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_WAIT, ST_XFER, ST_HOLD, ST_BACK
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/tgt_decode.sv
module tgt_decode #(
  parameter int               BUS_W     = 32,
  parameter int               IDX_W     = 4,
  parameter logic [BUS_W-1:0] BASE_ADDR = '0
) (
  input  logic [BUS_W-1:0] addr_i,
  input  logic [3:0]       cmd_i,
  output logic             hit_o,
  output logic             rd_o,
  output logic [IDX_W-1:0] idx_o
);
  import tgt_pkg::*;
  localparam int LSB = IDX_W + 2;

  logic cmd_ok, win_ok;

  assign cmd_ok = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_WR);
  assign win_ok = (addr_i[BUS_W-1:LSB] == BASE_ADDR[BUS_W-1:LSB]) && (addr_i[1:0] == 2'b00);
  assign hit_o  = cmd_ok && win_ok;
  assign rd_o   = (cmd_i == CMD_MEM_RD);
  assign idx_o  = addr_i[LSB-1:2];
endmodule

// File: rtl/tgt_regfile.sv
module tgt_regfile #(
  parameter int BUS_W = 32,
  parameter int WORDS = 16,
  parameter int IDX_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [BUS_W/8-1:0] be_ni,
  output logic [BUS_W-1:0]   rdata_o
);
  localparam int NBYTES = BUS_W / 8;

  logic [BUS_W-1:0] mem [WORDS];
  logic [BUS_W-1:0] lane_mask;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{~be_ni[b]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (we_i) begin
      mem[idx_i] <= (mem[idx_i] & ~lane_mask) | (wdata_i & lane_mask);
    end
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/tgt_fsm.sv
module tgt_fsm #(
  parameter int IDX_W     = 4,
  parameter int INIT_WAIT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             hit_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] start_idx_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             we_o,
  output logic             devsel_no,
  output logic             trdy_no,
  output logic             stop_no,
  output logic             ctl_oe_o,
  output logic             ad_oe_o
);
  import tgt_pkg::*;
  localparam int WCNT_W = (INIT_WAIT > 0) ? $clog2(INIT_WAIT + 1) : 1;
  localparam logic [WCNT_W-1:0] WLOAD = WCNT_W'(INIT_WAIT - 1);

  tgt_state_e        state;
  logic              frame_q, rd_q, start, xfer, last;
  logic [WCNT_W-1:0] wcnt;
  logic [IDX_W-1:0]  idx;

  assign start = (state == ST_IDLE) && !frame_ni && frame_q;
  assign xfer  = (state == ST_XFER) && !irdy_ni;
  assign last  = (idx == {IDX_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      frame_q <= 1'b1;
      rd_q    <= 1'b0;
      wcnt    <= '0;
      idx     <= '0;
    end else begin
      frame_q <= frame_ni;
      unique case (state)
        ST_IDLE: if (start && hit_i) begin
          rd_q <= rd_i;
          idx  <= start_idx_i;
          wcnt <= WLOAD;
          if (rd_i)               state <= ST_TURN;
          else if (INIT_WAIT > 0) state <= ST_WAIT;
          else                    state <= ST_XFER;
        end
        ST_TURN: begin
          wcnt  <= WLOAD;
          state <= (INIT_WAIT > 0) ? ST_WAIT : ST_XFER;
        end
        ST_WAIT: begin
          if (wcnt == '0) state <= ST_XFER;
          else            wcnt  <= wcnt - 1'b1;
        end
        ST_XFER: if (xfer) begin
          if (frame_ni)  state <= ST_BACK;
          else if (last) state <= ST_HOLD;
          else           idx   <= idx + 1'b1;
        end
        ST_HOLD: if (frame_ni) state <= ST_BACK;
        ST_BACK: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idx_o     = idx;
  assign we_o      = xfer && !rd_q;
  assign devsel_no = !(state inside {ST_TURN, ST_WAIT, ST_XFER, ST_HOLD});
  assign trdy_no   = !(state == ST_XFER);
  assign stop_no   = !(((state == ST_XFER) && last) || (state == ST_HOLD));
  assign ctl_oe_o  = (state != ST_IDLE);
  assign ad_oe_o   = rd_q && ((state == ST_WAIT) || (state == ST_XFER));
endmodule

// File: rtl/bus_target_ctrl.sv
module bus_target_ctrl #(
  parameter int               BUS_W     = 32,
  parameter int               WORDS     = 16,
  parameter int               INIT_WAIT = 1,
  parameter logic [BUS_W-1:0] BASE_ADDR = 32'h0000_1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_ni,
  input  logic               irdy_ni,
  input  logic [BUS_W-1:0]   ad_i,
  input  logic [BUS_W/8-1:0] cbe_ni,
  output logic [BUS_W-1:0]   ad_o,
  output logic               ad_oe_o,
  output logic               devsel_no,
  output logic               trdy_no,
  output logic               stop_no,
  output logic               ctl_oe_o
);
  localparam int IDX_W = $clog2(WORDS);

  logic             hit, rd, we;
  logic [IDX_W-1:0] start_idx, idx;

  tgt_decode #(.BUS_W(BUS_W), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i (ad_i),
    .cmd_i  (cbe_ni[3:0]),
    .hit_o  (hit),
    .rd_o   (rd),
    .idx_o  (start_idx)
  );

  tgt_fsm #(.IDX_W(IDX_W), .INIT_WAIT(INIT_WAIT)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_ni    (frame_ni),
    .irdy_ni     (irdy_ni),
    .hit_i       (hit),
    .rd_i        (rd),
    .start_idx_i (start_idx),
    .idx_o       (idx),
    .we_o        (we),
    .devsel_no   (devsel_no),
    .trdy_no     (trdy_no),
    .stop_no     (stop_no),
    .ctl_oe_o    (ctl_oe_o),
    .ad_oe_o     (ad_oe_o)
  );

  tgt_regfile #(.BUS_W(BUS_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .idx_i   (idx),
    .wdata_i (ad_i),
    .be_ni   (cbe_ni),
    .rdata_o (ad_o)
  );
endmodule

// File: rtl/tgt_checker.sv
module tgt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_ni,
  input logic irdy_ni,
  input logic devsel_no,
  input logic trdy_no,
  input logic stop_no,
  input logic ctl_oe_o,
  input logic ad_oe_o
);
  a_r2_ready_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no || !stop_no) |-> !devsel_no);

  a_r4_ready_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && irdy_ni) |=> !trdy_no);

  a_r5_ad_driven_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && trdy_no) |=> ad_oe_o);

  a_r7_release_after_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && !irdy_ni && frame_ni) |=> (trdy_no && devsel_no));

  a_r8_drive_high_before_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!devsel_no || !trdy_no || !stop_no) |=> ctl_oe_o);

  a_r10_stop_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_no && trdy_no && !frame_ni) |=> !stop_no);
endmodule

bind bus_target_ctrl tgt_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_ni  (frame_ni),
  .irdy_ni   (irdy_ni),
  .devsel_no (devsel_no),
  .trdy_no   (trdy_no),
  .stop_no   (stop_no),
  .ctl_oe_o  (ctl_oe_o),
  .ad_oe_o   (ad_oe_o)
);

// File: tb/bus_target_ctrl_test.sv
`timescale 1ns/1ps
module bus_target_ctrl_test;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [3:0]  RD   = 4'b0110;
  localparam logic [3:0]  WR   = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b1, irdy = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model [16];
  logic [31:0] got [16];

  always #5 clk = ~clk;

  bus_target_ctrl #(.BASE_ADDR(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame), .irdy_ni(irdy),
    .ad_i(ad), .cbe_ni(cbe), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .devsel_no(devsel_n), .trdy_no(trdy_n), .stop_no(stop_n), .ctl_oe_o(ctl_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wdata(input int seed, input int k);
    return 32'(seed) * 32'h0100_0193 + 32'(k) * 32'h9E37_79B9 + 32'h5A5A_0001;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be_n);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (!be_n[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // Claimed transaction; returns words moved, stop seen, iteration of first transfer
  task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                      input logic [3:0] be_n, input int seed, input int stall_j,
                      output int moved, output bit stop_seen, output int first_j);
    bit rd = (cmd == RD);
    int base_w = int'(addr[5:2]);
    int j = 0;
    moved = 0; stop_seen = 0; first_j = -1;
    @(negedge clk);
    frame = 1'b0; irdy = 1'b1; ad = addr; cbe = cmd;
    @(negedge clk);
    while (moved < n && !stop_seen && j < 60) begin
      irdy  = (j == stall_j);
      frame = (moved == n - 1);
      ad    = rd ? 32'h0 : wdata(seed, moved);
      cbe   = rd ? 4'h0 : be_n;
      #1;
      if (j == 0) begin
        check(!devsel_n, "R1 claim devsel", {31'b0, devsel_n}, 32'h0);
        check(!ad_oe, "R3 turnaround ad_oe", {31'b0, ad_oe}, 32'h0);
      end
      if (j == 1 && rd)
        check(ad_oe && trdy_n, "R5 ad driven in wait", {30'b0, ad_oe, trdy_n}, 32'h3);
      if (!trdy_n && !irdy) begin
        if (!stop_n) stop_seen = 1;
        if (rd) got[moved] = ad_o;
        else model[base_w + moved] = merge(model[base_w + moved], wdata(seed, moved), be_n);
        if (first_j < 0) first_j = j;
        moved++;
      end
      j++;
      @(negedge clk);
    end
    if (stop_seen && !frame) begin
      #1;
      check(!stop_n && trdy_n, "R10 stop held", {30'b0, stop_n, trdy_n}, 32'h1);
      frame = 1'b1; irdy = 1'b0;
      @(negedge clk);
    end
    frame = 1'b1; irdy = 1'b1; ad = '0; cbe = '0;
    #1;
    check(ctl_oe && devsel_n && trdy_n && stop_n, "R7 R8 drive high",
          {28'b0, ctl_oe, devsel_n, trdy_n, stop_n}, 32'hF);
    @(negedge clk); #1;
    check(!ctl_oe, "R8 release", {31'b0, ctl_oe}, 32'h0);
  endtask

  task automatic miss(input logic [3:0] cmd, input logic [31:0] addr);
    @(negedge clk);
    frame = 1'b0; irdy = 1'b1; ad = addr; cbe = cmd;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      frame = 1'b1; irdy = 1'b0; ad = 32'hDEAD_BEEF; cbe = 4'h0;
      #1;
      check(devsel_n && trdy_n && !ctl_oe, "R1 not claimed", {29'b0, devsel_n, trdy_n, ctl_oe}, 32'h6);
    end
    @(negedge clk);
    irdy = 1'b1; ad = '0;
    @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    int mv, fj; bit st;
    xact(RD, BASE, 16, 4'h0, 0, -1, mv, st, fj);
    check(mv == 16, "R9 full burst count", 32'(mv), 32'd16);
    for (int w = 0; w < 16; w++)
      check(got[w] === model[w], tag, got[w], model[w]);
  endtask

  initial begin
    int mv, fj, exp_mv; bit st;
    for (int w = 0; w < 16; w++) model[w] = '0;
    #1;
    check(devsel_n && trdy_n && stop_n && !ctl_oe && !ad_oe, "R11 reset outputs",
          {27'b0, devsel_n, trdy_n, stop_n, ctl_oe, ad_oe}, 32'h1C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 zero contents, R10 stop on last word, R3 read latency
    xact(RD, BASE, 16, 4'h0, 0, -1, mv, st, fj);
    check(st, "R10 stop at window end", {31'b0, st}, 32'h1);
    check(fj == 2, "R3 read first ready", 32'(fj), 32'd2);
    for (int w = 0; w < 16; w++) check(got[w] === 32'h0, "R11 zero after reset", got[w], 32'h0);

    // R9 R10 R3 start-word sweep with 3-word bursts
    for (int s = 0; s < 16; s++) begin
      xact(WR, BASE + 32'(s * 4), 3, 4'(s) ^ 4'hA, s + 1, -1, mv, st, fj);
      exp_mv = (16 - s < 3) ? 16 - s : 3;
      check(mv == exp_mv, "R10 words moved", 32'(mv), 32'(exp_mv));
      check(st == (s + 2 >= 15), "R10 stop presence", {31'b0, st}, {31'b0, s + 2 >= 15});
      check(fj == 1, "R3 write first ready", 32'(fj), 32'd1);
    end
    read_all("R9 burst readback");

    // R6 byte-enable sweep on word 5
    for (int be = 0; be < 16; be++) begin
      xact(WR, BASE + 32'd20, 1, 4'(be), 100 + be, -1, mv, st, fj);
      xact(RD, BASE + 32'd20, 1, 4'h0, 0, -1, mv, st, fj);
      check(got[0] === model[5], "R6 byte lanes", got[0], model[5]);
    end

    // R4 initiator stalls
    xact(RD, BASE + 32'd8, 4, 4'h0, 0, 3, mv, st, fj);
    for (int k = 0; k < 4; k++) check(got[k] === model[2 + k], "R4 stalled read", got[k], model[2 + k]);
    xact(WR, BASE + 32'd32, 3, 4'h0, 77, 2, mv, st, fj);
    check(mv == 3, "R4 stalled write count", 32'(mv), 32'd3);

    // R1 unclaimed cycles leave contents untouched
    miss(WR, BASE + 32'd64);
    miss(WR, BASE - 32'd4);
    miss(4'b0011, BASE);
    miss(WR, BASE + 32'd2);
    read_all("R1 R4 readback");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule